// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block turns each incoming PWM waveform into a pair of complementary drive signals, a true output and an inverted output, with a dead band at every switching point. At each PWM edge the output that was high drops in the next cycle. The output that is about to go high waits for a programmed number of prescaler ticks before it rises, so both switches of a half-bridge are never on together.

The delays for the two rising edges are set separately in one 8-bit configuration register. The upper nibble holds the delay before the true output rises. The lower nibble holds the delay before the inverted output rises. The same register serves every channel of the block. Time is counted only in cycles where the prescaler tick input is high. The PWM source and the prescaler sit outside the block.

Top module: `dtg_top`

## Requirements
- R1: After reset, the configuration register reads 0x00 on `cfgRdData` and both outputs of every channel are low.
- R2: With `cfgWrEn` high at a clock edge, `cfgWrData` is stored and appears on `cfgRdData` from the next cycle on.
- R3: When a channel's PWM input falls, `outTrue` is low from the cycle after the edge is sampled. `outInv` rises on the (L+1)-th tick after the edge cycle, where L is register bits 3:0.
- R4: When a channel's PWM input rises, `outInv` is low from the cycle after the edge is sampled. `outTrue` rises on the (H+1)-th tick after the edge cycle, where H is register bits 7:4.
- R5: A delay value of 0 makes the pending output rise on the first tick after the edge cycle.
- R6: A tick in the edge cycle is not counted. Without a tick the delay does not advance and no output rises.
- R7: If the PWM input toggles back before the pending output has risen, that output stays low, and the delay restarts with the value for the new edge.
- R8: `outTrue` and `outInv` of a channel are never high in the same cycle.
- R9: All channels use the same register value, and each channel times its own edges independently.
- R10: A register write in the same cycle as a PWM edge does not affect that edge. The edge uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | NUM_CH | PWM input, one bit per channel |
| tickEn | input | 1 | Prescaled timer tick, high for one cycle per period |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrData | input | 2*DLY_W | Write data: [7:4] true-rise delay, [3:0] inverted-rise delay |
| cfgRdData | output | 2*DLY_W | Current register value |
| outTrue | output | NUM_CH | True drive output per channel |
| outInv | output | NUM_CH | Inverted drive output per channel |

## Verification
Two functions can meet in one clock cycle. A register write can land in the same cycle as a PWM edge, and a prescaler tick can coincide with that edge or with the expiry of the count. The bench provokes the first case directly: it drives a new delay value and a PWM rise on the same edge, then measures the rise latency, which must follow the old nibble. Random traffic with frequent ticks produces the second case many times. Each cycle a bench model built from the requirements judges both outputs of every channel.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
  // Strobes from control to datapath, one set per channel
  typedef struct packed {
    logic load;   // edge seen: reload counter, drop both outputs
    logic dec;    // tick while counting down
    logic fire;   // tick with counter at zero: raise pending output
    logic side;   // 1: the true output is the one pending
  } dtgStrobe_t;
endpackage

// File: rtl/dtg_ctrl.sv
`timescale 1ns/1ps
module dtg_ctrl
  import dtg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       tickEn,
  input  logic       cntZero,
  output dtgStrobe_t st
);
  logic pwmQ;
  logic pending;
  logic edgeSeen;

  assign edgeSeen = (pwmIn != pwmQ);

  always_comb begin
    st.load = edgeSeen;
    st.side = edgeSeen ? pwmIn : pwmQ;
    st.dec  = !edgeSeen && pending && tickEn && !cntZero;
    st.fire = !edgeSeen && pending && tickEn && cntZero;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmQ    <= 1'b0;
      pending <= 1'b1;
    end else if (edgeSeen) begin
      pwmQ    <= pwmIn;
      pending <= 1'b1;
    end else if (st.fire) begin
      pending <= 1'b0;
    end
  end

  // R7: a new edge always re-arms the pending rise
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> pending);
  // R6: nothing progresses in a cycle without a tick
  a_r6_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |-> !(st.dec || st.fire));
endmodule

// File: rtl/dtg_datapath.sv
`timescale 1ns/1ps
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dtgStrobe_t       st,
  input  logic [DLY_W-1:0] dlyTrue,
  input  logic [DLY_W-1:0] dlyInv,
  output logic             cntZero,
  output logic             outTrue,
  output logic             outInv
);
  logic [DLY_W-1:0] cnt;
  logic             trueQ;
  logic             invQ;

  assign cntZero = (cnt == '0);
  assign outTrue = trueQ;
  assign outInv  = invQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      trueQ <= 1'b0;
      invQ  <= 1'b0;
    end else if (st.load) begin
      cnt   <= st.side ? dlyTrue : dlyInv;
      trueQ <= 1'b0;
      invQ  <= 1'b0;
    end else if (st.dec) begin
      cnt <= cnt - DLY_W'(1);
    end else if (st.fire) begin
      if (st.side) trueQ <= 1'b1;
      else         invQ  <= 1'b1;
    end
  end

  // R8: complementary outputs never overlap
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(outTrue && outInv));
  // R4: rising PWM edge drops the inverted output next cycle
  a_r4_inv_drop: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && st.side) |=> !outInv && !outTrue);
  // R3: falling PWM edge drops the true output next cycle
  a_r3_true_drop: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && !st.side) |=> !outTrue && !outInv);
  // R6: no tick and no edge leaves the count and outputs frozen
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(st.load || st.dec || st.fire) |=> $stable(cnt) && $stable(outTrue) && $stable(outInv));
endmodule

// File: rtl/dtg_top.sv
`timescale 1ns/1ps
module dtg_top
  import dtg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DLY_W  = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CH-1:0]    pwmIn,
  input  logic                 tickEn,
  input  logic                 cfgWrEn,
  input  logic [2*DLY_W-1:0]   cfgWrData,
  output logic [2*DLY_W-1:0]   cfgRdData,
  output logic [NUM_CH-1:0]    outTrue,
  output logic [NUM_CH-1:0]    outInv
);
  localparam int CFG_W = 2 * DLY_W;

  logic [CFG_W-1:0] cfgQ;
  logic [DLY_W-1:0] dlyTrue;
  logic [DLY_W-1:0] dlyInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cfgQ <= '0;
    else if (cfgWrEn) cfgQ <= cfgWrData;
  end

  assign cfgRdData = cfgQ;
  assign dlyTrue   = cfgQ[CFG_W-1:DLY_W];
  assign dlyInv    = cfgQ[DLY_W-1:0];

  // R2: write data becomes visible on the read port one cycle later
  a_r2_write: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == $past(cfgWrData));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    dtgStrobe_t st;
    logic       cntZero;

    dtg_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .pwmIn   (pwmIn[ch]),
      .tickEn  (tickEn),
      .cntZero (cntZero),
      .st      (st)
    );

    dtg_datapath #(.DLY_W(DLY_W)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .st      (st),
      .dlyTrue (dlyTrue),
      .dlyInv  (dlyInv),
      .cntZero (cntZero),
      .outTrue (outTrue[ch]),
      .outInv  (outInv[ch])
    );

    // R4: the true output only rises on a tick while PWM is high
    a_r4_true_rise: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outTrue[ch]) |-> $past(pwmIn[ch]) && $past(tickEn));
    // R3: the inverted output only rises on a tick while PWM is low
    a_r3_inv_rise: assert property (@(posedge clk) disable iff (!rstN)
      $rose(outInv[ch]) |-> !$past(pwmIn[ch]) && $past(tickEn));
  end
endmodule

// File: tb/dtg_top_tb.sv
`timescale 1ns/1ps
module dtg_top_tb;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] pwmIn = '0;
  logic           tickEn = 1'b0;
  logic           cfgWrEn = 1'b0;
  logic [7:0]     cfgWrData = '0;
  logic [7:0]     cfgRdData;
  logic [NCH-1:0] outTrue;
  logic [NCH-1:0] outInv;

  int    nChk = 0;
  int    nFail = 0;
  int    cycles = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string curTag = "R1";

  // reference model state
  bit [7:0] mReg;
  bit       mPwmQ [NCH];
  bit       mPend [NCH];
  bit [3:0] mCnt  [NCH];
  bit       mTrue [NCH];
  bit       mInv  [NCH];

  dtg_top #(.NUM_CH(NCH), .DLY_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .tickEn(tickEn),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .outTrue(outTrue), .outInv(outInv)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  endtask

  // model from the requirements: edge drops both, pending rises on (N+1)-th later tick
  always @(posedge clk) begin
    if (!rstN) begin
      mReg = 8'h00;
      for (int c = 0; c < NCH; c++) begin
        mPwmQ[c] = 1'b0; mPend[c] = 1'b1; mCnt[c] = 4'd0;
        mTrue[c] = 1'b0; mInv[c] = 1'b0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (pwmIn[c] != mPwmQ[c]) begin
          mPwmQ[c] = pwmIn[c];
          mPend[c] = 1'b1;
          mCnt[c]  = pwmIn[c] ? mReg[7:4] : mReg[3:0];
          mTrue[c] = 1'b0; mInv[c] = 1'b0;
        end else if (mPend[c] && tickEn) begin
          if (mCnt[c] == 4'd0) begin
            if (mPwmQ[c]) mTrue[c] = 1'b1; else mInv[c] = 1'b1;
            mPend[c] = 1'b0;
          end else begin
            mCnt[c] = mCnt[c] - 4'd1;
          end
        end
      end
      if (cfgWrEn) mReg = cfgWrData; // after edges: R10 old value used
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (running) begin
      chk(cfgRdData == mReg, {curTag, " R2 reg"}, cfgRdData, mReg);
      for (int c = 0; c < NCH; c++) begin
        chk(outTrue[c] == mTrue[c], {curTag, " outTrue"}, outTrue[c], mTrue[c]);
        chk(outInv[c] == mInv[c], {curTag, " outInv"}, outInv[c], mInv[c]);
        chk(!(outTrue[c] && outInv[c]), "R8 overlap", {outTrue[c], outInv[c]}, 0);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finishRun();
    end
  end

  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a PWM level on a channel with ticks every cycle; count negedges until the pending output is high
  task automatic measure(input int ch, input bit lvl, input bit alsoWr, input logic [7:0] wv, output int n);
    @(negedge clk);
    pwmIn[ch] = lvl;
    if (alsoWr) begin cfgWrEn = 1'b1; cfgWrData = wv; end
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      cfgWrEn = 1'b0;
      n++;
      if (lvl ? outTrue[ch] : outInv[ch]) break;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd2718));
    idle(3);
    rstN = 1'b1;
    running = 1'b1;
    // R1 reset state, checked before any active edge
    chk(cfgRdData == 8'h00, "R1 reg", cfgRdData, 0);
    chk(outTrue == '0 && outInv == '0, "R1 outs", {outTrue, outInv}, 0);

    // R2 register write / readback
    writeReg(8'h53);
    chk(cfgRdData == 8'h53, "R2 readback", cfgRdData, 8'h53);

    // R3/R4 latency with tick every cycle: rise seen at negedge H+2 (edge cycle + H+1 ticks)
    tickEn = 1'b1; curTag = "R4";
    idle(5);
    measure(0, 1'b1, 1'b0, 8'h00, n);
    chk(n == 5 + 2, "R4 true latency", n, 7);
    curTag = "R3";
    measure(0, 1'b0, 1'b0, 8'h00, n);
    chk(n == 3 + 2, "R3 inv latency", n, 5);

    // R5 zero delay
    writeReg(8'h00); curTag = "R5";
    measure(0, 1'b1, 1'b0, 8'h00, n);
    chk(n == 2, "R5 zero true", n, 2);
    measure(0, 1'b0, 1'b0, 8'h00, n);
    chk(n == 2, "R5 zero inv", n, 2);

    // R6 edge-cycle tick ignored, no progress without ticks
    writeReg(8'h11); curTag = "R6";
    @(negedge clk); tickEn = 1'b1; pwmIn[1] = 1'b1;
    @(negedge clk); tickEn = 1'b0;
    idle(10);
    chk(outTrue[1] == 1'b0, "R6 held without tick", outTrue[1], 0);
    tickEn = 1'b1; @(negedge clk);
    chk(outTrue[1] == 1'b0, "R6 first tick counts down", outTrue[1], 0);
    @(negedge clk);
    chk(outTrue[1] == 1'b1, "R6 second tick fires", outTrue[1], 1);

    // R7 glitch: toggle back before expiry
    writeReg(8'hF2); curTag = "R7";
    @(negedge clk); pwmIn[0] = 1'b1;
    idle(4);
    pwmIn[0] = 1'b0;
    idle(1);
    chk(outTrue[0] == 1'b0, "R7 pending stays low", outTrue[0], 0);
    idle(3);
    chk(outInv[0] == 1'b1, "R7 restart with inv delay", outInv[0], 1);
    chk(outTrue[0] == 1'b0, "R7 true never rose", outTrue[0], 0);

    // R9 both channels on one setting
    writeReg(8'h40); curTag = "R9";
    @(negedge clk); pwmIn[0] = 1'b0; pwmIn[1] = 1'b0;
    idle(4);
    @(negedge clk); pwmIn[0] = 1'b1; pwmIn[1] = 1'b1;
    idle(5);
    chk(outTrue == 2'b00, "R9 both still waiting", outTrue, 0);
    idle(1);
    chk(outTrue == 2'b11, "R9 both rise together", outTrue, 3);

    // R10 write in edge cycle: old H=2 used, not new H=9
    writeReg(8'h22); curTag = "R10";
    pwmIn[1] = 1'b0; idle(6);
    measure(1, 1'b1, 1'b1, 8'h99, n);
    chk(n == 2 + 2, "R10 old value used", n, 4);
    chk(cfgRdData == 8'h99, "R10 new value stored", cfgRdData, 8'h99);

    // random traffic
    curTag = "R3 R4 R7 R8 R9 random";
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        if ($urandom % 10 == 0) pwmIn[c] = ~pwmIn[c];
      tickEn  = ($urandom % 3) != 0;
      cfgWrEn = ($urandom % 150) == 0;
      cfgWrData = 8'($urandom % 4) | (8'($urandom % 4) << 4);
    end
    @(negedge clk); cfgWrEn = 1'b0;
    idle(3);
    running = 1'b0;
    finishRun();
  end
endmodule